// File: doc/BRIEF.md
# Bit-Serial Adder with Shift Registers

This block adds two unsigned operands of `WIDTH` bits by handling one bit position per clock. Each operand is held in its own shift register that can also take a parallel value. While an addition runs, both registers move right by one place every cycle, so their least significant bits meet at a one-bit adder cell. The sum bit from that cell enters the top end of the first operand register. After `WIDTH` cycles that register holds the whole sum. The second register fills with zeros. The only state carried from one bit time to the next is a single carry element with set and reset inputs in the style of a JK flip-flop.

A user presents both operands together with a `load_i` pulse and then pulses `start_i`. The controller has three states. `ST_IDLE` waits for work. `ST_SHIFT` performs one bit time per cycle. `ST_FINISH` lasts a single cycle and raises `done_o`. The transitions are:
- **go**: `ST_IDLE` or `ST_FINISH` to `ST_SHIFT`, taken on an accepted start.
- **last bit**: `ST_SHIFT` to `ST_FINISH`, taken when the bit counter reaches `WIDTH-1`.
- **retire**: `ST_FINISH` to `ST_IDLE`, taken when no start is present.
- **stay**: `ST_SHIFT` holds itself while bits remain.

Top module: `bitser_adder`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `busy_o` and `done_o` are 0, `sum_o` is 0 and `cout_o` is 0.
- R2: A `load_i` pulse while `busy_o` is 0 makes `sum_o` equal `opa_i` on the next cycle, clears `cout_o` and stores `opb_i` as the second operand.
- R3: A `start_i` pulse while `busy_o` is 0 and `load_i` is 0 makes `busy_o` go high on the next cycle. It then stays high for exactly `WIDTH` cycles.
- R4: `done_o` is high for exactly one cycle, namely the cycle right after `busy_o` falls. `busy_o` and `done_o` are never high together.
- R5: While `done_o` is high, `sum_o` equals `(opa + opb) mod 2^WIDTH` and `cout_o` equals bit `WIDTH` of `opa + opb`.
- R6: Each bit time adds the two operand LSBs and the stored carry, with sum = x XOR y XOR carry. The carry becomes 1 when both bits are 1, becomes 0 when both are 0, and keeps its value otherwise. After k bit times, the upper k bits of `sum_o` hold the low k bits of the sum, and `cout_o` holds the carry out of bit k-1.
- R7: `load_i` and `start_i` are ignored while `busy_o` is high. The running addition finishes with the result of the operands it started with, and its timing does not change.
- R8: When `load_i` and `start_i` are high in the same cycle while idle, the load takes place and the start is ignored, so `busy_o` stays 0.
- R9: While idle, with no load and no start, `sum_o` and `cout_o` keep their values whatever `opa_i` and `opb_i` do.
- R10: An accepted start clears the carry. Because the second operand register refills with zeros, a second start without a new load leaves the sum unchanged and gives a `cout_o` of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Strobe that captures both operands |
| opa_i | input | WIDTH | First operand; its register later holds the sum |
| opb_i | input | WIDTH | Second operand |
| start_i | input | 1 | Begins an addition of the stored operands |
| busy_o | output | 1 | High during the `WIDTH` bit times |
| done_o | output | 1 | One-cycle pulse after the last bit time |
| sum_o | output | WIDTH | Contents of the first operand / sum register |
| cout_o | output | 1 | Stored carry; the final carry out once done |

## Verification
The bench checks the partial sum and the carry after every single bit time. A carry element that sets, clears or holds on the wrong input pair therefore shows up at the exact bit where it goes wrong, and is not hidden in a final value that happens to match. Operands with all ones, with 0 plus 0, and with a full carry ripple test the boundaries. A design with a bit counter that is off by one would keep `busy_o` high for the wrong number of cycles and would leave the sum rotated by one place. A load or start that leaks through while busy would corrupt the result. A design that does not clear the carry on start would report a stale carry-out on a second run. A design where start beats load in the same cycle would begin adding too soon.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } bsa_state_e;

endpackage

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] ld_val,
    input  logic             shift,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out
);

    logic [WIDTH-1:0] shifted;

    // right shift: each bit takes its upper neighbour, MSB takes the serial input
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            if (gi == WIDTH - 1) begin : g_top
                assign shifted[gi] = ser_in;
            end else begin : g_mid
                assign shifted[gi] = q[gi+1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= ld_val;
        end else if (shift) begin
            q <= shifted;
        end
    end

    assign ser_out = q[0];

    // R9
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(q));

endmodule

// File: rtl/bsa_carry_cell.sv
module bsa_carry_cell (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    input  logic x,
    input  logic y,
    output logic sum_bit,
    output logic carry
);

    logic set_in;
    logic rst_in;
    logic carry_nx;

    always_comb begin
        set_in   = x & y;
        rst_in   = ~(x | y);
        carry_nx = (set_in & ~carry) | (~rst_in & carry);
        sum_bit  = x ^ y ^ carry;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            carry <= 1'b0;
        end else if (en) begin
            carry <= carry_nx;
        end
    end

    // R6
    carry_set_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && x && y) |=> carry);

    // R6
    carry_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && !x && !y) |=> !carry);

    // R6
    carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && (x != y)) |=> $stable(carry));

endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load_req,
    input  logic start_req,
    output logic load_en,
    output logic shift_en,
    output logic carry_clr,
    output logic busy,
    output logic done
);

    import bsa_pkg::*;

    localparam int            CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    bsa_state_e    state;
    bsa_state_e    state_nx;
    logic [CW-1:0] bit_cnt;
    logic          open;
    logic          start_go;

    always_comb begin
        open     = (state != ST_SHIFT);
        load_en  = load_req && open;
        start_go = start_req && !load_req && open;
    end

    // state register and bit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= state_nx;
            if (start_go) begin
                bit_cnt <= '0;
            end else if (state == ST_SHIFT) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_go) state_nx = ST_SHIFT;
            ST_SHIFT:  if (bit_cnt == LAST) state_nx = ST_FINISH;
            ST_FINISH: state_nx = start_go ? ST_SHIFT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        shift_en  = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        carry_clr = load_en || start_go;
        unique case (state)
            ST_IDLE:   ;
            ST_SHIFT: begin
                shift_en = 1'b1;
                busy     = 1'b1;
            end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && bit_cnt != LAST) |=> busy);

endmodule

// File: rtl/bitser_adder.sv
module bitser_adder #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic             load_en;
    logic             shift_en;
    logic             carry_clr;
    logic             a_lsb;
    logic             b_lsb;
    logic             sum_bit;
    logic             carry_q;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;

    bsa_ctrl #(.WIDTH(WIDTH)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .load_req  (load_i),
        .start_req (start_i),
        .load_en   (load_en),
        .shift_en  (shift_en),
        .carry_clr (carry_clr),
        .busy      (busy_o),
        .done      (done_o)
    );

    bsa_shreg #(.WIDTH(WIDTH)) a_reg_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load_en),
        .ld_val  (opa_i),
        .shift   (shift_en),
        .ser_in  (sum_bit),
        .q       (a_q),
        .ser_out (a_lsb)
    );

    bsa_shreg #(.WIDTH(WIDTH)) b_reg_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load_en),
        .ld_val  (opb_i),
        .shift   (shift_en),
        .ser_in  (1'b0),
        .q       (b_q),
        .ser_out (b_lsb)
    );

    bsa_carry_cell carry_i (
        .clk     (clk),
        .rst     (rst),
        .en      (shift_en),
        .clr     (carry_clr),
        .x       (a_lsb),
        .y       (b_lsb),
        .sum_bit (sum_bit),
        .carry   (carry_q)
    );

    assign sum_o  = a_q;
    assign cout_o = carry_q;

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !busy_o) |=> (sum_o == $past(opa_i)) && !cout_o);

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && start_i && !busy_o) |=> !busy_o);

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !load_i && !start_i) |=> ($stable(sum_o) && $stable(cout_o)));

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !load_i && !busy_o) |=> !cout_o);

    // second register drains to zero by the end of a run
    b_drained_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (b_q == '0));

endmodule

// File: tb/bitser_adder_tb_top.sv
module bitser_adder_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] sum_o;
    logic         cout_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    bitser_adder #(.WIDTH(W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .start_i (start_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .sum_o   (sum_o),
        .cout_o  (cout_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_load(input int a, input int b);
        @(negedge clk);
        load_i = 1'b1;
        opa_i  = W'(a);
        opb_i  = W'(b);
        @(negedge clk);
        load_i = 1'b0;
        chk(sum_o == W'(a), "R2 sum_o after load", int'(sum_o), a);
        chk(cout_o == 1'b0, "R2 cout after load", int'(cout_o), 0);
    endtask

    // runs one addition of stored a,b and checks every bit time
    task automatic run_add(input int a, input int b, input bit noise);
        int full;
        full = a + b;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R3 busy after start", int'(busy_o), 1);
        for (int k = 1; k <= W; k++) begin
            if (noise && k == 2) begin
                load_i  = 1'b1;
                start_i = 1'b1;
                opa_i   = 8'hA5;
                opb_i   = 8'h5A;
            end
            @(negedge clk);
            load_i  = 1'b0;
            start_i = 1'b0;
            begin
                int mask;
                int exp_hi;
                int exp_c;
                int act_hi;
                mask   = (1 << k) - 1;
                exp_hi = full & mask;
                exp_c  = (((a & mask) + (b & mask)) >> k) & 1;
                act_hi = int'(sum_o) >> (W - k);
                chk(act_hi == exp_hi, "R6 partial sum", act_hi, exp_hi);
                chk(int'(cout_o) == exp_c, "R6 partial carry", int'(cout_o), exp_c);
            end
            if (k < W) begin
                chk(busy_o == 1'b1, "R3 busy during run", int'(busy_o), 1);
                chk(done_o == 1'b0, "R4 done early", int'(done_o), 0);
            end
        end
        chk(busy_o == 1'b0, "R3 busy after W cycles", int'(busy_o), 0);
        chk(done_o == 1'b1, "R4 done pulse", int'(done_o), 1);
        chk(int'(sum_o) == (full & ((1 << W) - 1)), "R5 final sum", int'(sum_o),
            full & ((1 << W) - 1));
        chk(int'(cout_o) == ((full >> W) & 1), "R5 final carry", int'(cout_o),
            (full >> W) & 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R4 done one cycle", int'(done_o), 0);
        chk(busy_o == 1'b0, "R4 busy stays low", int'(busy_o), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0, "R1 flags in reset", int'({busy_o, done_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sum_o == '0, "R1 sum after reset", int'(sum_o), 0);
        chk(cout_o == 1'b0, "R1 cout after reset", int'(cout_o), 0);
        chk(busy_o == 0 && done_o == 0, "R1 flags after reset", int'({busy_o, done_o}), 0);
    endtask

    task automatic t_add(input int a, input int b);
        do_load(a, b);
        run_add(a, b, 1'b0);
    endtask

    task automatic t_busy_ignore;
        do_load(8'h3C, 8'hC7);
        run_add(8'h3C, 8'hC7, 1'b1); // R7
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        load_i  = 1'b1;
        start_i = 1'b1;
        opa_i   = 8'd77;
        opb_i   = 8'd99;
        @(negedge clk);
        load_i  = 1'b0;
        start_i = 1'b0;
        chk(busy_o == 1'b0, "R8 start ignored with load", int'(busy_o), 1'b0);
        chk(sum_o == 8'd77, "R8 load taken", int'(sum_o), 77);
        run_add(77, 99, 1'b0);
    endtask

    task automatic t_idle_stable;
        logic [W-1:0] s0;
        logic         c0;
        s0 = sum_o;
        c0 = cout_o;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            opa_i = W'(i * 37 + 11);
            opb_i = W'(i * 91 + 3);
            @(negedge clk);
            chk(sum_o == s0, "R9 sum stable idle", int'(sum_o), int'(s0));
            chk(cout_o == c0, "R9 cout stable idle", int'(cout_o), int'(c0));
        end
    endtask

    task automatic t_restart;
        do_load(200, 100);
        run_add(200, 100, 1'b0);
        run_add(44, 0, 1'b0); // R10: second start adds zero, carry cleared
    endtask

    initial begin : watchdog
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        t_reset();
        t_add(8'd23, 8'd45);
        t_add(8'hFF, 8'hFF);
        t_add(8'd0, 8'd0);
        t_add(8'hFF, 8'h01);
        t_add(8'h55, 8'hAA);
        t_busy_ignore();
        t_same_cycle();
        t_idle_stable();
        t_restart();
        t_idle_stable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule